// File: doc/BRIEF.md
# Phase Comparator with Masked Lock Detector

This block sits in the digital half of a motor speed loop. It takes a reference clock and a tachometer feedback pulse, samples both into the system clock domain, and measures the time between the falling edge of the reference and the rising edge of the feedback. The signed error leaves the block as two pulse outputs. Pump-up is high for as many system clocks as the reference edge leads. Pump-down is high for as many clocks as the feedback edge leads. A downstream filter turns the duty of these pulses into a speed correction. In regulation the feedback runs at the reference frequency, so each reference period holds one edge pair.

Each completed edge pair is judged against a window of `WIN_CLKS` system clocks, and the result sets or clears a raw alignment flag. The lock output is a masked version of that flag. It rises only after `MASK_TICKS` ticks of a slow timebase have passed with the flag held high the whole time. Short misalignments caused by hunting during pull-in therefore restart the mask but never produce a short lock pulse. A gain-select output follows the masked lock, so the servo can halve its forward and reverse gain once the loop is locked.

Top module: `phase_lock_det`

## Requirements
- R1: When the reference falls d clocks before the feedback rises (0 < d), `pump_up_o` is high for exactly d consecutive clocks and `pump_dn_o` stays low.
- R2: When the feedback rises d clocks before the reference falls (0 < d), `pump_dn_o` is high for exactly d consecutive clocks and `pump_up_o` stays low.
- R3: `pump_up_o` and `pump_dn_o` are never high in the same cycle. Edges that are sampled in the same clock give no pulse at all.
- R4: `aligned_o` is set by an edge pair whose separation is at most `WIN_CLKS` clocks. It is cleared as soon as an open measurement exceeds `WIN_CLKS` clocks, or when a second edge of the same kind arrives before its partner.
- R5: `lock_o` rises on the clock after the `MASK_TICKS`-th `tick_i` pulse counted while `aligned_o` is high (default 7). Before that tick it stays low.
- R6: Any loss of alignment drops `lock_o` within one clock and restarts the tick count from zero.
- R7: `gain_half_o` equals `lock_o` in every cycle (1 = halved servo gain, 0 = full gain).
- R8: While `en_i` is low, both pump outputs, `aligned_o`, the tick count and `lock_o` are held at zero. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low clears the comparator and the lock state |
| ref_clk_i | input | 1 | Reference clock; its falling edge is the phase reference |
| fb_i | input | 1 | Tachometer feedback; its rising edge is the measured phase |
| tick_i | input | 1 | One-clock pulse of the slow timebase that paces the mask |
| pump_up_o | output | 1 | Accelerate pulse, high while the reference leads |
| pump_dn_o | output | 1 | Decelerate pulse, high while the feedback leads |
| aligned_o | output | 1 | Raw phase-aligned flag |
| lock_o | output | 1 | Masked lock indication, active high |
| gain_half_o | output | 1 | Servo gain select: 1 = half gain, 0 = full gain |

## Verification
Two pairs of functions can fall in the same clock. The first pair is the opening and closing edges: a reference fall and a feedback rise that are sampled together. The bench provokes this with a zero offset and expects no pump cycles at all, while the alignment flag is still set. The second pair is the window judgement and the mask: offsets of exactly `WIN_CLKS` and `WIN_CLKS+1` sit on either side of the boundary. A single out-of-window period placed after lock is reached must drop lock and restart the seven-tick count. The bench predicts this from its own tick and alignment model.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_DN   = 2'd2
  } ph_state_e;
endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic ev_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sig_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign ev_o = s3_q & ~s2_q;
    end else begin : g_rise
      assign ev_o = ~s3_q & s2_q;
    end
  endgenerate
endmodule

// File: rtl/pld_phase_cmp.sv
module pld_phase_cmp
  import pld_pkg::*;
#(
  parameter int WIN_CLKS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_ev_i,
  input  logic fb_ev_i,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic good_o,
  output logic bad_o
);
  localparam int CW = $clog2(WIN_CLKS + 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(WIN_CLKS + 1);

  ph_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_inc;
    good_o  = 1'b0;
    bad_o   = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (ref_ev_i && fb_ev_i) begin
          good_o = 1'b1;
        end else if (ref_ev_i) begin
          state_d = PH_UP;
          cnt_d   = CW'(1);
        end else if (fb_ev_i) begin
          state_d = PH_DN;
          cnt_d   = CW'(1);
        end
      end
      PH_UP: begin
        if (fb_ev_i) begin
          good_o  = (cnt_q != CNT_MAX);
          state_d = ref_ev_i ? PH_UP : PH_IDLE;
          cnt_d   = ref_ev_i ? CW'(1) : '0;
        end else if (ref_ev_i) begin
          bad_o = 1'b1;  // missed feedback edge
          cnt_d = CW'(1);
        end
      end
      PH_DN: begin
        if (ref_ev_i) begin
          good_o  = (cnt_q != CNT_MAX);
          state_d = fb_ev_i ? PH_DN : PH_IDLE;
          cnt_d   = fb_ev_i ? CW'(1) : '0;
        end else if (fb_ev_i) begin
          bad_o = 1'b1;  // missed reference edge
          cnt_d = CW'(1);
        end
      end
      default: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (state_q != PH_IDLE && cnt_q == CNT_MAX) bad_o = 1'b1;
    if (!en_i) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
      good_o  = 1'b0;
      bad_o   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pump_up_o = (state_q == PH_UP);
  assign pump_dn_o = (state_q == PH_DN);

  a_r3_pumps_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pump_up_o && pump_dn_o));
  a_r1_up_ends_on_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pump_up_o && fb_ev_i && !ref_ev_i) |=> !pump_up_o);
  a_r2_dn_ends_on_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pump_dn_o && ref_ev_i && !fb_ev_i) |=> !pump_dn_o);
  a_r8_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pump_up_o && !pump_dn_o));
endmodule

// File: rtl/pld_lock_mask.sv
module pld_lock_mask #(
  parameter int MASK_TICKS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic good_i,
  input  logic bad_i,
  input  logic tick_i,
  output logic aligned_o,
  output logic lock_o
);
  localparam int MW = $clog2(MASK_TICKS + 1);
  localparam logic [MW-1:0] LAST = MW'(MASK_TICKS - 1);

  logic          aligned_q, lock_q;
  logic [MW-1:0] tick_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
    end else if (!en_i || bad_i) begin
      aligned_q <= 1'b0;
    end else if (good_i) begin
      aligned_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      lock_q     <= 1'b0;
    end else if (!en_i || !aligned_q) begin
      tick_cnt_q <= '0;
      lock_q     <= 1'b0;
    end else if (tick_i && !lock_q) begin
      if (tick_cnt_q == LAST) lock_q <= 1'b1;
      else                    tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end

  assign aligned_o = aligned_q;
  assign lock_o    = lock_q;

  a_r4_bad_clears_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |=> !aligned_q);
  a_r6_unaligned_drops_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned_q |=> !lock_q);
  a_r5_lock_rises_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(tick_i));
  a_r8_disable_clears_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!lock_q && !aligned_q));
endmodule

// File: rtl/phase_lock_det.sv
module phase_lock_det #(
  parameter int WIN_CLKS   = 6,
  parameter int MASK_TICKS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_clk_i,
  input  logic fb_i,
  input  logic tick_i,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic aligned_o,
  output logic lock_o,
  output logic gain_half_o
);
  localparam int NSIG = 2;
  localparam logic [NSIG-1:0] FALL_SEL = 2'b01;  // [0] ref falls, [1] fb rises

  logic [NSIG-1:0] raw, ev;
  logic good, bad;

  assign raw = {fb_i, ref_clk_i};

  generate
    for (genvar i = 0; i < NSIG; i++) begin : g_sync
      pld_edge_sync #(.FALLING(FALL_SEL[i])) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sig_i (raw[i]),
        .ev_o  (ev[i])
      );
    end
  endgenerate

  pld_phase_cmp #(.WIN_CLKS(WIN_CLKS)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .ref_ev_i (ev[0]),
    .fb_ev_i  (ev[1]),
    .pump_up_o(pump_up_o),
    .pump_dn_o(pump_dn_o),
    .good_o   (good),
    .bad_o    (bad)
  );

  pld_lock_mask #(.MASK_TICKS(MASK_TICKS)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .good_i   (good),
    .bad_i    (bad),
    .tick_i   (tick_i),
    .aligned_o(aligned_o),
    .lock_o   (lock_o)
  );

  assign gain_half_o = lock_o;
endmodule

// File: tb/phase_lock_det_tb.sv
module phase_lock_det_tb;
  localparam int WIN  = 6;
  localparam int MASK = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ref_r = 1'b1, fb_r = 1'b0, tick = 1'b0;
  logic pump_up, pump_dn, aligned, lock, gain_half;

  int n_chk = 0, n_bad = 0;
  int exp_cnt = 0;
  bit exp_aligned = 0, done = 0;

  always #4 clk = ~clk;

  phase_lock_det #(.WIN_CLKS(WIN), .MASK_TICKS(MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ref_clk_i(ref_r), .fb_i(fb_r),
    .tick_i(tick), .pump_up_o(pump_up), .pump_dn_o(pump_dn),
    .aligned_o(aligned), .lock_o(lock), .gain_half_o(gain_half)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit in_window(input int d);
    return absv(d) <= WIN;
  endfunction

  // one reference period; positive delta means the reference leads
  task automatic run_period(input int delta);
    int up_n = 0, dn_n = 0, both_n = 0;
    ref_r = 1'b1;
    fb_r  = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      up_n   += int'(pump_up);
      dn_n   += int'(pump_dn);
      both_n += int'(pump_up & pump_dn);
      if (delta >= 0) begin
        if (i == 10) ref_r = 1'b0;
        if (i == 10 + delta) fb_r = 1'b1;
      end else begin
        if (i == 10) fb_r = 1'b1;
        if (i == 10 - delta) ref_r = 1'b0;
      end
    end
    if (en) begin
      check("R1 pump_up width", up_n, (delta > 0) ? delta : 0);
      check("R2 pump_dn width", dn_n, (delta < 0) ? -delta : 0);
      exp_aligned = in_window(delta);
      if (!exp_aligned) exp_cnt = 0;
      check("R4 aligned", int'(aligned), int'(exp_aligned));
    end else begin
      check("R8 pumps idle while disabled", up_n + dn_n, 0);
      check("R8 aligned off while disabled", int'(aligned), 0);
      exp_aligned = 0;
      exp_cnt = 0;
    end
    check("R3 overlap cycles", both_n, 0);
  endtask

  task automatic do_tick(input bit fire);
    if (fire) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (exp_aligned && exp_cnt < MASK) exp_cnt++;
    end
    @(negedge clk);
    check(exp_cnt >= MASK ? "R5 lock high" : "R6 lock low", int'(lock),
          int'(exp_cnt >= MASK));
    check("R7 gain follows lock", int'(gain_half), int'(exp_cnt >= MASK));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset pump_up", int'(pump_up), 0);
    check("R8 reset lock", int'(lock), 0);
    check("R8 reset aligned", int'(aligned), 0);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (5) @(negedge clk);

    // boundary cases
    run_period(0);       do_tick(1);   // R3 coincident edges
    run_period(WIN);     do_tick(1);
    run_period(-WIN);    do_tick(1);
    run_period(WIN + 1); do_tick(1);   // R4 just outside
    run_period(-(WIN + 1)); do_tick(1);
    // reach lock, then one hunting glitch
    for (int k = 0; k < MASK + 2; k++) begin
      run_period(k % 3 - 1);
      do_tick(1);
    end
    check("R5 locked after mask", int'(lock), 1);
    run_period(WIN + 3); do_tick(0);   // R6 drop
    check("R6 lock cleared", int'(lock), 0);
    for (int k = 0; k < 3; k++) begin
      run_period(2); do_tick(1);
    end
    // disable clears everything
    en = 1'b0;
    run_period(3); do_tick(1);
    check("R8 lock off while disabled", int'(lock), 0);
    en = 1'b1;
    // random periods
    for (int k = 0; k < 150; k++) begin
      int d;
      if ($urandom_range(99) < 85) d = $urandom_range(2 * WIN) - WIN;
      else d = $urandom_range(2 * (WIN + 6)) - (WIN + 6);
      run_period(d);
      do_tick($urandom_range(99) < 70);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule